// File: doc/BRIEF.md
# Serial I/Q Sample Formatter

This block takes parallel in-phase (I) and quadrature (Q) samples and sends them out bit by bit on a slow serial clock. It derives that serial clock from the system clock. A word-start strobe goes active for one serial period just before the first bit of every word, so a receiver can find word boundaries without counting.

Two layouts are supported. In parallel-lane mode, the I and Q words go out in the same serial slots on two data lines. In interleaved mode, a 16-bit I word and then a 16-bit Q word go out on the I line. Bit 0 of each interleaved word tells the receiver which word it is.

The bit order, the strobe polarity and the division ratio are configuration inputs. These must be held stable while words are in flight. One sample pair can wait behind a transfer in progress. A pair arriving while that slot is occupied is discarded and reported on a one-cycle flag.

Top module: `iq_serializer`

## Requirements
- R1: `cfg_div` sets the serial period. Code 1 gives 2 system cycles, code 2 gives 4 and code 3 gives 8; `sclk_out` is low in the first half of each period and high in the second half. Code 0 holds `sclk_out` at 1, and every system cycle is one serial slot.
- R2: `sdata_i`, `sdata_q` and `word_start` change only at the boundary between serial periods, where `sclk_out` falls. They are therefore stable across each rising edge of `sclk_out`.
- R3: The strobe is active for exactly one serial slot, and that slot is the one immediately before the first data bit of each word. It is never active while data bits are being sent.
- R4: With `cfg_ilv`=0, the I sample goes out on `sdata_i` and the Q sample on `sdata_q` in the same slots. Each word is `SAMPLE_W` bits with no padding.
- R5: With `cfg_ilv`=1, each pair goes out on `sdata_i` as an I word and then a Q word, each `ILV_W` (16) bits and each led by its own strobe. A word holds the sample in bits 15..6 and zeros in bits 5..1. Bit 0 is 1 for an I word and 0 for a Q word. `sdata_q` stays 0 in this mode.
- R6: With `cfg_lsb_first`=1, bit 0 of the word is sent first. With `cfg_lsb_first`=0, the most significant bit is sent first.
- R7: With `cfg_strobe_low`=0 the strobe is active high. With `cfg_strobe_low`=1 it is active low, so `word_start` rests at 1 when idle.
- R8: A pair presented while a transfer runs and the holding slot is empty is kept. Its strobe occupies the slot right after the last bit of the current pair, with no idle slot between.
- R9: A pair presented while the holding slot is already full is discarded and never sent. `overrun` is high for exactly one system cycle, the cycle after that `in_valid`.
- R10: During and right after reset, the data lines are 0, `overrun` is 0 and the strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 2 | Serial rate code: 0 = ÷1, 1 = ÷2, 2 = ÷4, 3 = ÷8 |
| cfg_ilv | input | 1 | 1 = interleaved I/Q words on one line, 0 = two parallel lines |
| cfg_lsb_first | input | 1 | 1 = send bit 0 first |
| cfg_strobe_low | input | 1 | 1 = word strobe active low |
| in_valid | input | 1 | One-cycle pulse qualifying `in_i`/`in_q` |
| in_i | input | SAMPLE_W | In-phase sample |
| in_q | input | SAMPLE_W | Quadrature sample |
| sclk_out | output | 1 | Serial clock |
| sdata_i | output | 1 | I line (and the shared line in interleaved mode) |
| sdata_q | output | 1 | Q line |
| word_start | output | 1 | Word-start strobe |
| overrun | output | 1 | One-cycle pulse: a sample pair was dropped |

## Verification
A pair is picked up at the first serial boundary after it is latched, which is at most one serial period later. From then on, each serial slot lasts exactly the programmed number of system cycles. The bench therefore decodes the stream at the observed rising edges of `sclk_out`, sampling at falling system-clock edges, rather than predicting absolute cycle numbers. It checks that every slot lasts exactly the programmed number of cycles and that strobes are spaced word length plus one slots apart. `overrun` is due exactly one system cycle after the rejected `in_valid`, and the bench samples it at the next falling edge. The sweep covers every combination of rate, layout, bit order and polarity.

// File: rtl/iq_serializer.sv
module iq_serializer #(
  parameter int SAMPLE_W = 10,
  parameter int ILV_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_div,
  input  logic                cfg_ilv,
  input  logic                cfg_lsb_first,
  input  logic                cfg_strobe_low,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                sclk_out,
  output logic                sdata_i,
  output logic                sdata_q,
  output logic                word_start,
  output logic                overrun
);
  localparam int PW    = $clog2(ILV_W + 1);
  localparam int IW    = $clog2(ILV_W);
  localparam int SHIFT = ILV_W - SAMPLE_W;

  logic [2:0]          cnt;
  logic                tick;
  logic                busy, second, pend_v;
  logic [PW-1:0]       pos, len, idx;
  logic [ILV_W-1:0]    cur_i, cur_q;
  logic [SAMPLE_W-1:0] pend_i, pend_q;
  logic                last, take, strobe_act, data_slot;

  always_comb begin
    case (cfg_div)
      2'd0:    begin tick = 1'b1;      sclk_out = 1'b1;   end
      2'd1:    begin tick = cnt[0];    sclk_out = cnt[0]; end
      2'd2:    begin tick = &cnt[1:0]; sclk_out = cnt[1]; end
      default: begin tick = &cnt;      sclk_out = cnt[2]; end
    endcase
  end

  assign len        = cfg_ilv ? PW'(ILV_W) : PW'(SAMPLE_W);
  assign last       = busy && (pos == len);
  assign take       = tick && pend_v && (!busy || (last && !second));
  assign strobe_act = busy && (pos == '0);
  assign data_slot  = busy && (pos != '0);
  assign idx        = cfg_lsb_first ? pos - 1'b1 : len - pos;
  assign sdata_i    = data_slot && cur_i[idx[IW-1:0]];
  assign sdata_q    = data_slot && !cfg_ilv && cur_q[idx[IW-1:0]];
  assign word_start = strobe_act ^ cfg_strobe_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; busy <= 1'b0; second <= 1'b0; pos <= '0;
      cur_i <= '0; cur_q <= '0; pend_v <= 1'b0; pend_i <= '0; pend_q <= '0;
      overrun <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      overrun <= in_valid && pend_v && !take;
      if (take) pend_v <= 1'b0;
      if (in_valid && (!pend_v || take)) begin
        pend_v <= 1'b1;
        pend_i <= in_i;
        pend_q <= in_q;
      end
      if (tick) begin
        if (take) begin
          busy   <= 1'b1;
          pos    <= '0;
          second <= cfg_ilv;
          if (cfg_ilv) begin
            cur_i <= (ILV_W'(pend_i) << SHIFT) | ILV_W'(1);
            cur_q <= ILV_W'(pend_q) << SHIFT;
          end else begin
            cur_i <= ILV_W'(pend_i);
            cur_q <= ILV_W'(pend_q);
          end
        end else if (last) begin
          if (second) begin
            second <= 1'b0;
            pos    <= '0;
            cur_i  <= cur_q;
          end else begin
            busy <= 1'b0;
          end
        end else if (busy) begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos) && $stable(busy) && $stable(cur_i));

  a_r3_strobe_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_act && tick |=> !strobe_act);

  a_r5_id_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ilv && busy && (cfg_lsb_first ? pos == PW'(1) : pos == PW'(ILV_W)) |-> sdata_i == second);

  a_r9_flag_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> pend_v);

endmodule

// File: tb/iq_serializer_tb.sv
`timescale 1ns/1ps
module iq_serializer_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_div = 0;
  logic cfg_ilv = 0, cfg_lsb_first = 0, cfg_strobe_low = 0, in_valid = 0;
  logic [9:0] in_i = 0, in_q = 0;
  logic sclk_out, sdata_i, sdata_q, word_start, overrun;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iq_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_ilv(cfg_ilv),
    .cfg_lsb_first(cfg_lsb_first), .cfg_strobe_low(cfg_strobe_low),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .sclk_out(sclk_out),
    .sdata_i(sdata_i), .sdata_q(sdata_q), .word_start(word_start), .overrun(overrun));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int nper, wlen;
  int cyc, slot, last_stb, nstb, k, nw, ov_cnt;
  int per_bad, chg_bad, q_bad, gap_bad, stb_bad;
  bit first_ev, coll, p_sclk;
  logic [2:0] p_out;
  logic [15:0] acc_i, acc_q;
  int rx_i[0:7], rx_q[0:7];

  always @(negedge clk) begin
    bit ev, stb;
    int bp;
    if (!rst_n) begin
      first_ev = 1; coll = 0; nw = 0; nstb = 0; slot = 0; cyc = 0; k = 0;
      per_bad = 0; chg_bad = 0; q_bad = 0; gap_bad = 0; stb_bad = 0; ov_cnt = 0;
      last_stb = 0; acc_i = 0; acc_q = 0;
    end else begin
      ev = (nper == 1) || (sclk_out && !p_sclk);
      if (nper > 1 && {word_start, sdata_i, sdata_q} != p_out && !(p_sclk && !sclk_out))
        chg_bad++;
      if (overrun) ov_cnt++;
      if (cfg_ilv && sdata_q) q_bad++;
      cyc++;
      if (ev) begin
        if (!first_ev && cyc != nper) per_bad++;
        first_ev = 0; cyc = 0; slot++;
        stb = word_start ^ cfg_strobe_low;
        if (coll) begin
          if (stb) stb_bad++;
          bp = cfg_lsb_first ? k : wlen - 1 - k;
          acc_i[bp] = sdata_i;
          acc_q[bp] = sdata_q;
          k++;
          if (k == wlen) begin
            if (nw < 8) begin rx_i[nw] = int'(acc_i); rx_q[nw] = int'(acc_q); end
            nw++; coll = 0;
          end
        end else if (stb) begin
          if (nstb > 0 && slot - last_stb != wlen + 1) gap_bad++;
          last_stb = slot; nstb++; coll = 1; k = 0; acc_i = 0; acc_q = 0;
        end
      end
    end
    p_sclk = sclk_out;
    p_out = {word_start, sdata_i, sdata_q};
  end

  task automatic send(input logic [9:0] vi, input logic [9:0] vq);
    @(negedge clk);
    in_valid = 1; in_i = vi; in_q = vq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 2; m++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 2; p++) begin
            int cfgn, nwords;
            logic [9:0] ai, aq, bi, bq;
            cfgn = d * 8 + m * 4 + o * 2 + p;
            ai = 10'(cfgn * 97 + 3);
            aq = 10'(~(cfgn * 53));
            bi = 10'h200 ^ 10'(cfgn);
            bq = 10'h3FF - 10'(cfgn);
            nper = 1 << d;
            wlen = m ? 16 : 10;
            nwords = m ? 4 : 2;
            @(negedge clk);
            rst_n = 0; in_valid = 0;
            cfg_div = 2'(d); cfg_ilv = m[0]; cfg_lsb_first = o[0]; cfg_strobe_low = p[0];
            repeat (3) @(negedge clk);
            chg_bad = 0;
            chk(word_start == p[0], "R7 idle strobe level", int'(word_start), p);
            chk(!sdata_i && !sdata_q && !overrun, "R10 reset outputs",
                int'({sdata_i, sdata_q, overrun}), 0);
            chk(sclk_out == (d == 0), "R1 sclk reset level", int'(sclk_out), int'(d == 0));
            rst_n = 1;
            send(ai, aq);
            @(negedge clk); in_valid = 0;
            repeat (2 * nper + 2) @(negedge clk);
            in_valid = 1; in_i = bi; in_q = bq;
            @(negedge clk);
            in_i = 10'h155; in_q = 10'h0AA;
            @(negedge clk);
            in_valid = 0;
            chk(overrun == 1'b1, "R9 overrun pulse timing", int'(overrun), 1);
            repeat (nper * (nwords * (wlen + 1) + 8)) @(negedge clk);
            chk(ov_cnt == 1, "R9 overrun one cycle", ov_cnt, 1);
            chk(nw == nwords, "R9 dropped pair not sent", nw, nwords);
            chk(per_bad == 0, "R1 serial period", per_bad, 0);
            chk(chg_bad == 0, "R2 outputs change at falling sclk", chg_bad, 0);
            chk(stb_bad == 0, "R3 strobe only before first bit", stb_bad, 0);
            chk(gap_bad == 0, "R8 back to back spacing", gap_bad, 0);
            if (m) begin
              chk(q_bad == 0, "R5 q line quiet", q_bad, 0);
              chk(rx_i[0] == ((int'(ai) << 6) | 1), "R5 R6 first I word", rx_i[0], (int'(ai) << 6) | 1);
              chk(rx_i[1] == (int'(aq) << 6), "R5 R6 first Q word", rx_i[1], int'(aq) << 6);
              chk(rx_i[2] == ((int'(bi) << 6) | 1), "R8 R5 held I word", rx_i[2], (int'(bi) << 6) | 1);
              chk(rx_i[3] == (int'(bq) << 6), "R8 R5 held Q word", rx_i[3], int'(bq) << 6);
            end else begin
              chk(rx_i[0] == int'(ai), "R4 R6 I lane", rx_i[0], int'(ai));
              chk(rx_q[0] == int'(aq), "R4 R6 Q lane", rx_q[0], int'(aq));
              chk(rx_i[1] == int'(bi), "R8 R4 held I", rx_i[1], int'(bi));
              chk(rx_q[1] == int'(bq), "R8 R4 held Q", rx_q[1], int'(bq));
            end
            chk(word_start == p[0] && !sdata_i && !sdata_q, "R7 R3 idle after transfer",
                int'({word_start, sdata_i, sdata_q}), p << 2);
          end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule